// File: doc/BRIEF.md
# Serial Multiplexer Register File

This block is the processor-facing register set of a sixteen-line asynchronous serial multiplexer. Eight 16-bit registers sit at even byte offsets inside a 16-byte window. Five registers are shared by all lines: control, received character, active-transmit mask, break mask and silo status. Three registers are banked per line: line parameters, current address and byte count. The line number held in the low bits of the control register chooses which bank a bus access reaches.

Reads and writes arrive on a simple synchronous strobe interface. Read data appears one cycle after the read strobe. Several accesses have side effects. A received-character read empties that register and clears the receive interrupt. A control write can clear the whole block, or raise or drop the transmit interrupt. A current-address write takes two extension bits from the control register. Writes to the active mask and byte count registers send start and cancel pulses to the transmit engine.

The receiver delivers characters through a one-cycle strobe. The transmit engine reports a finished line through a one-cycle strobe. The serial shifters, the character silo and the DMA engine are outside this block.

Top module: `mux_regs_top`

## Requirements
- R1: After reset every register and every per-line bank is zero. Both interrupt requests, both strobes, `activeMask`, `breakMask` and `busRdata` are low.
- R2: Register select is `busAddr[3:1]`, and `busAddr[0]` is ignored. The byte offsets are: 0 control, 2 received character, 4 line parameters, 6 current address, 8 byte count, 10 active mask, 12 break mask, 14 silo status. `busRdata` carries the read value in the cycle after `busRd` and is zero in every other cycle.
- R3: Control bits 3:0 select the line whose parameter, current-address and byte-count registers are read or written.
- R4: A current-address write stores an 18-bit address: control bits 5:4 go to bits 17:16 and the written word goes to bits 15:0. A read returns bits 15:0.
- R5: The line-parameter register always reads as zero. A write to the received-character offset has no effect.
- R6: On `rxValid` the received-character register loads the following value. Bit 15 is set. Bits 11:8 hold `rxLine`. The low bits hold `rxChar` masked to 5 + P bits, where P is bits 1:0 of that line's parameter register. Control bit 7 is set, and `rxIrq` is raised if control bit 6 is set.
- R7: Reading the received-character register returns its value, then zeroes it, clears control bit 7 and drops `rxIrq`. An `rxValid` in the same cycle is loaded after the clear.
- R8: A control write with bit 15 set raises `txIrq` if the written bit 13 is set, and leaves it unchanged otherwise. A control write with bit 15 clear drops `txIrq`, and pulses `txStart` if the active mask is non-zero.
- R9: A control write with bit 11 set clears every register, every bank and both interrupt requests.
- R10: `txDone` clears bit `txDoneLine` of the active mask and sets control bit 15. It raises `txIrq` if control bit 13 is set.
- R11: Writing the active mask stores it on `activeMask`. The cycle after a write of zero, `txCancel` pulses. The cycle after a non-zero write, `txStart` pulses. A byte-count write of zero also pulses `txCancel`. The two pulses never coincide.
- R12: A silo-status write changes only bits 15 and 5:0. A silo-status read first loads bits 7:6 with bits 17:16 of the selected line's current address, and that value is kept.
- R13: The break-mask register is read/write and drives `breakMask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 4 | Byte offset in the window |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, one cycle after busRd |
| rxValid | input | 1 | Received character strobe |
| rxLine | input | 4 | Line of the received character |
| rxChar | input | 8 | Received character |
| txDone | input | 1 | Transmit engine finished a line |
| txDoneLine | input | 4 | Line that finished |
| rxIrq | output | 1 | Receive interrupt request |
| txIrq | output | 1 | Transmit interrupt request |
| txStart | output | 1 | Start pulse to transmit engine |
| txCancel | output | 1 | Cancel pulse to transmit engine |
| activeMask | output | 16 | Lines with transmission active |
| breakMask | output | 16 | Per-line break control |

## Verification
The assertions assume the bus never raises `busWr` and `busRd` together. Where an assertion concerns the interrupt or mask state, its antecedent excludes a coincident `rxValid` or `txDone`, because those strobes change the same state. The bench drives a single bus strobe per cycle. It places receive and transmit-done strobes in cycles of their own, except for one deliberate collision between a received-character read and `rxValid`.

// File: rtl/mux_regs_pkg.sv
package mux_regs_pkg;

  localparam int WORD_W     = 16;
  localparam int EXT_W      = 2;
  localparam int CHAR_W     = 8;

  // control register bit positions
  localparam int CB_RIE     = 6;
  localparam int CB_RXF     = 7;
  localparam int CB_MCLR    = 11;
  localparam int CB_OIE     = 13;
  localparam int CB_TXF     = 15;
  localparam int CB_EXT_LO  = 4;
  localparam int RX_VALID_B = 15;
  localparam int RX_LINE_LO = 8;
  localparam logic [WORD_W-1:0] SILO_KEEP = 16'h7FC0;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_RXCH = 3'd1,
    SEL_LPAR = 3'd2,
    SEL_CADR = 3'd3,
    SEL_BCNT = 3'd4,
    SEL_BACT = 3'd5,
    SEL_BRK  = 3'd6,
    SEL_SILO = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    mclr;
    logic    wrLpar;
    logic    wrCadr;
    logic    wrBcnt;
    logic    wrBact;
    logic    wrBrk;
    logic    wrSilo;
    logic    wrZero;
    logic    rdAny;
    logic    rdRxch;
    logic    rdSilo;
    regSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/mux_regs_ctrl.sv
module mux_regs_ctrl
  import mux_regs_pkg::*;
(
  input  logic              busWr,
  input  logic              busRd,
  input  logic [2:0]        regIdx,
  input  logic [WORD_W-1:0] busWdata,
  output strobes_t          strb
);

  regSel_e sel;

  always_comb begin
    sel         = regSel_e'(regIdx);
    strb        = '0;
    strb.rdSel  = sel;
    strb.rdAny  = busRd;
    strb.wrZero = (busWdata == '0);
    if (busWr) begin
      unique case (sel)
        SEL_CTRL: begin
          strb.wrCtrl = 1'b1;
          strb.mclr   = busWdata[CB_MCLR];
        end
        SEL_LPAR: strb.wrLpar = 1'b1;
        SEL_CADR: strb.wrCadr = 1'b1;
        SEL_BCNT: strb.wrBcnt = 1'b1;
        SEL_BACT: strb.wrBact = 1'b1;
        SEL_BRK:  strb.wrBrk  = 1'b1;
        SEL_SILO: strb.wrSilo = 1'b1;
        default:  ;
      endcase
    end
    if (busRd) begin
      strb.rdRxch = (sel == SEL_RXCH);
      strb.rdSilo = (sel == SEL_SILO);
    end
  end

endmodule

// File: rtl/mux_regs_dp.sv
module mux_regs_dp
  import mux_regs_pkg::*;
#(
  parameter int NLINES = 16,
  localparam int LW = $clog2(NLINES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [WORD_W-1:0] busWdata,
  input  logic              rxValid,
  input  logic [LW-1:0]     rxLine,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              txDone,
  input  logic [LW-1:0]     txDoneLine,
  output logic [WORD_W-1:0] busRdata,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              txStart,
  output logic              txCancel,
  output logic [NLINES-1:0] activeMask,
  output logic [NLINES-1:0] breakMask
);

  localparam int AW = WORD_W + EXT_W;

  logic [WORD_W-1:0] ctrlReg, rxchReg, siloReg;
  logic [NLINES-1:0] bactReg, brkReg;
  logic [WORD_W-1:0] lparArr [NLINES];
  logic [AW-1:0]     cadrArr [NLINES];
  logic [WORD_W-1:0] bcntArr [NLINES];
  logic [LW-1:0]     lineSel;
  logic [WORD_W-1:0] rdVal, rxWord, siloView;
  logic [CHAR_W-1:0] charMask;

  assign lineSel  = ctrlReg[LW-1:0];
  assign siloView = {siloReg[WORD_W-1:8], cadrArr[lineSel][AW-1:WORD_W], siloReg[5:0]};

  always_comb begin
    charMask = CHAR_W'((9'd1 << (5 + int'(lparArr[rxLine][1:0]))) - 9'd1);
    rxWord = '0;
    rxWord[CHAR_W-1:0] = rxChar & charMask;
    rxWord[RX_LINE_LO +: LW] = rxLine;
    rxWord[RX_VALID_B] = 1'b1;
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_CTRL: rdVal = ctrlReg;
      SEL_RXCH: rdVal = rxchReg;
      SEL_LPAR: rdVal = '0;
      SEL_CADR: rdVal = cadrArr[lineSel][WORD_W-1:0];
      SEL_BCNT: rdVal = bcntArr[lineSel];
      SEL_BACT: rdVal = WORD_W'(bactReg);
      SEL_BRK:  rdVal = WORD_W'(brkReg);
      SEL_SILO: rdVal = siloView;
      default:  rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0; rxchReg <= '0; siloReg <= '0;
      bactReg <= '0; brkReg <= '0; busRdata <= '0;
      rxIrq <= 1'b0; txIrq <= 1'b0; txStart <= 1'b0; txCancel <= 1'b0;
      for (int i = 0; i < NLINES; i++) begin
        lparArr[i] <= '0; cadrArr[i] <= '0; bcntArr[i] <= '0;
      end
    end else if (strb.mclr) begin
      ctrlReg <= '0; rxchReg <= '0; siloReg <= '0;
      bactReg <= '0; brkReg <= '0; busRdata <= '0;
      rxIrq <= 1'b0; txIrq <= 1'b0; txStart <= 1'b0; txCancel <= 1'b0;
      for (int i = 0; i < NLINES; i++) begin
        lparArr[i] <= '0; cadrArr[i] <= '0; bcntArr[i] <= '0;
      end
    end else begin
      txStart  <= 1'b0;
      txCancel <= 1'b0;
      busRdata <= strb.rdAny ? rdVal : '0;

      if (strb.wrCtrl) begin
        ctrlReg <= busWdata;
        if (busWdata[CB_TXF]) begin
          if (busWdata[CB_OIE]) txIrq <= 1'b1;
        end else begin
          txIrq <= 1'b0;
          if (bactReg != '0) txStart <= 1'b1;
        end
      end
      if (strb.wrLpar) lparArr[lineSel] <= busWdata;
      if (strb.wrCadr) cadrArr[lineSel] <= {ctrlReg[CB_EXT_LO +: EXT_W], busWdata};
      if (strb.wrBcnt) begin
        bcntArr[lineSel] <= busWdata;
        if (strb.wrZero) txCancel <= 1'b1;
      end
      if (strb.wrBact) begin
        bactReg <= busWdata[NLINES-1:0];
        if (busWdata[NLINES-1:0] == '0) txCancel <= 1'b1;
        else                            txStart  <= 1'b1;
      end
      if (strb.wrBrk)  brkReg <= busWdata[NLINES-1:0];
      if (strb.wrSilo) siloReg <= (siloReg & SILO_KEEP) | (busWdata & ~SILO_KEEP);
      if (strb.rdSilo) siloReg <= siloView;

      if (strb.rdRxch) begin
        rxchReg <= '0;
        ctrlReg[CB_RXF] <= 1'b0;
        rxIrq <= 1'b0;
      end
      if (rxValid) begin
        rxchReg <= rxWord;
        ctrlReg[CB_RXF] <= 1'b1;
        if (ctrlReg[CB_RIE]) rxIrq <= 1'b1;
      end
      if (txDone) begin
        bactReg[txDoneLine] <= 1'b0;
        ctrlReg[CB_TXF] <= 1'b1;
        if (ctrlReg[CB_OIE]) txIrq <= 1'b1;
      end
    end
  end

  assign activeMask = bactReg;
  assign breakMask  = brkReg;

endmodule

// File: rtl/mux_regs_top.sv
module mux_regs_top
  import mux_regs_pkg::*;
#(
  parameter int NLINES = 16,
  localparam int LW = $clog2(NLINES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [3:0]        busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [LW-1:0]     rxLine,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              txDone,
  input  logic [LW-1:0]     txDoneLine,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              txStart,
  output logic              txCancel,
  output logic [NLINES-1:0] activeMask,
  output logic [NLINES-1:0] breakMask
);

  strobes_t strb;

  mux_regs_ctrl i_ctrl (
    .busWr    (busWr),
    .busRd    (busRd),
    .regIdx   (busAddr[3:1]),
    .busWdata (busWdata),
    .strb     (strb)
  );

  mux_regs_dp #(.NLINES(NLINES)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWdata   (busWdata),
    .rxValid    (rxValid),
    .rxLine     (rxLine),
    .rxChar     (rxChar),
    .txDone     (txDone),
    .txDoneLine (txDoneLine),
    .busRdata   (busRdata),
    .rxIrq      (rxIrq),
    .txIrq      (txIrq),
    .txStart    (txStart),
    .txCancel   (txCancel),
    .activeMask (activeMask),
    .breakMask  (breakMask)
  );

endmodule

// File: rtl/mux_regs_chk.sv
module mux_regs_chk #(
  parameter int NLINES = 16
)(
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              busRd,
  input logic [3:0]        busAddr,
  input logic [15:0]       busWdata,
  input logic [15:0]       busRdata,
  input logic              rxValid,
  input logic              txDone,
  input logic              rxIrq,
  input logic              txIrq,
  input logic              txStart,
  input logic              txCancel,
  input logic [NLINES-1:0] activeMask
);

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> busRdata == 16'h0) else $error("idle rdata"); // R2

  AST_LPAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[3:1] == 3'd2) |=> busRdata == 16'h0) else $error("lpar read"); // R5

  AST_RXCH_READ_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[3:1] == 3'd1 && !rxValid) |=> !rxIrq) else $error("rx drop"); // R7

  AST_TXF_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[3:1] == 3'd0 && !busWdata[15] && !txDone) |=> !txIrq) else $error("tx drop"); // R8

  AST_MCLR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[3:1] == 3'd0 && busWdata[11])
      |=> (!rxIrq && !txIrq && activeMask == '0)) else $error("mclr"); // R9

  AST_BACT_START: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[3:1] == 3'd5 && busWdata[NLINES-1:0] != '0 && !txDone)
      |=> (txStart && activeMask == $past(busWdata[NLINES-1:0]))) else $error("start"); // R11

  AST_BACT_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[3:1] == 3'd5 && busWdata[NLINES-1:0] == '0) |=> txCancel) else $error("cancel"); // R11

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(txStart && txCancel)) else $error("both strobes"); // R11

endmodule

bind mux_regs_top mux_regs_chk #(.NLINES(NLINES)) i_chk (.*);

// File: tb/test_mux_regs_top.sv
module test_mux_regs_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        rxValid = 1'b0;
  logic [3:0]  rxLine = '0;
  logic [7:0]  rxChar = '0;
  logic        txDone = 1'b0;
  logic [3:0]  txDoneLine = '0;
  logic        rxIrq, txIrq, txStart, txCancel;
  logic [15:0] activeMask, breakMask;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mux_regs_top i_mux_regs_top (.*);

  // vector: {isRead, byte offset, write data or expected read data}
  localparam int NV = 25;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd0,  16'h0003},
    {1'b0, 4'd6,  16'h1234},
    {1'b0, 4'd0,  16'h0035},
    {1'b0, 4'd6,  16'hABCD},
    {1'b0, 4'd0,  16'h0003},
    {1'b1, 4'd6,  16'h1234},  // R3 R4
    {1'b0, 4'd0,  16'h0005},
    {1'b1, 4'd6,  16'hABCD},  // R3 R4
    {1'b0, 4'd4,  16'h0002},
    {1'b1, 4'd4,  16'h0000},  // R5
    {1'b0, 4'd8,  16'h00FF},
    {1'b1, 4'd8,  16'h00FF},  // R3
    {1'b0, 4'd0,  16'h0003},
    {1'b1, 4'd8,  16'h0000},  // R3
    {1'b0, 4'd12, 16'h00A5},
    {1'b1, 4'd12, 16'h00A5},  // R13
    {1'b0, 4'd0,  16'h0005},
    {1'b0, 4'd14, 16'hFFFF},
    {1'b1, 4'd14, 16'h80FF},  // R12
    {1'b0, 4'd14, 16'h0000},
    {1'b1, 4'd14, 16'h00C0},  // R12
    {1'b0, 4'd0,  16'h0003},
    {1'b1, 4'd14, 16'h0000},  // R12
    {1'b0, 4'd2,  16'h5555},
    {1'b1, 4'd2,  16'h0000}   // R5
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic doRd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
    v = busRdata;
  endtask

  task automatic doRx(input logic [3:0] ln, input logic [7:0] ch);
    @(negedge clk);
    rxValid = 1'b1; rxLine = ln; rxChar = ch;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  initial begin
    #(20ns * 100000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rxIrq", {15'd0, rxIrq}, 16'h0);
    check("R1 txIrq", {15'd0, txIrq}, 16'h0);
    check("R1 activeMask", activeMask, 16'h0);
    check("R1 breakMask", breakMask, 16'h0);
    check("R1 rdata", busRdata, 16'h0);
    doRd(4'd0, v); check("R1 ctrl", v, 16'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        doRd(VEC[i][19:16], v);
        check($sformatf("R2 vector %0d", i), v, VEC[i][15:0]);
      end else begin
        doWr(VEC[i][19:16], VEC[i][15:0]);
      end
    end

    // receive path
    doWr(4'd0, 16'h0045);
    doRx(4'd9, 8'hFF);
    check("R6 rxIrq raised", {15'd0, rxIrq}, 16'h1);
    doRd(4'd0, v); check("R6 ctrl flag", v, 16'h00C5);
    doRd(4'd2, v); check("R6 rx word 5-bit", v, 16'h891F);
    check("R7 rxIrq dropped", {15'd0, rxIrq}, 16'h0);
    doRd(4'd2, v); check("R7 cleared", v, 16'h0);
    doRd(4'd0, v); check("R7 ctrl flag clear", v, 16'h0045);
    doRx(4'd5, 8'hFF);
    doRd(4'd2, v); check("R6 rx word 7-bit", v, 16'h857F);
    doWr(4'd0, 16'h0005);
    doRx(4'd2, 8'h41);
    check("R6 no irq when disabled", {15'd0, rxIrq}, 16'h0);
    doRd(4'd0, v); check("R6 flag without enable", v, 16'h0085);
    doRd(4'd2, v); check("R6 rx word", v, 16'h8201);
    @(negedge clk);
    busRd = 1'b1; busAddr = 4'd2;
    rxValid = 1'b1; rxLine = 4'd1; rxChar = 8'h03;
    @(negedge clk);
    busRd = 1'b0; rxValid = 1'b0;
    check("R7 collision read", busRdata, 16'h0);
    doRd(4'd2, v); check("R7 load wins", v, 16'h8103);

    // break and active masks
    doWr(4'd12, 16'h00F0);
    check("R13 breakMask", breakMask, 16'h00F0);
    doWr(4'd10, 16'h0021);
    check("R11 start pulse", {15'd0, txStart}, 16'h1);
    check("R11 activeMask", activeMask, 16'h0021);
    @(negedge clk);
    check("R11 start single", {15'd0, txStart}, 16'h0);
    doWr(4'd8, 16'h0000);
    check("R11 bcnt cancel", {15'd0, txCancel}, 16'h1);
    doWr(4'd8, 16'h0003);
    check("R11 no cancel", {15'd0, txCancel}, 16'h0);

    // transmit interrupt
    doWr(4'd0, 16'h2000);
    check("R8 restart pulse", {15'd0, txStart}, 16'h1);
    check("R8 txIrq low", {15'd0, txIrq}, 16'h0);
    @(negedge clk);
    txDone = 1'b1; txDoneLine = 4'd5;
    @(negedge clk);
    txDone = 1'b0;
    check("R10 mask bit cleared", activeMask, 16'h0001);
    check("R10 txIrq", {15'd0, txIrq}, 16'h1);
    doRd(4'd0, v); check("R10 ctrl flag", v, 16'hA000);
    doWr(4'd0, 16'h2000);
    check("R8 drop", {15'd0, txIrq}, 16'h0);
    doWr(4'd0, 16'hA000);
    check("R8 raise", {15'd0, txIrq}, 16'h1);
    doWr(4'd0, 16'h8000);
    check("R8 unchanged", {15'd0, txIrq}, 16'h1);
    doWr(4'd0, 16'h0000);
    check("R8 drop again", {15'd0, txIrq}, 16'h0);
    check("R8 start on clear", {15'd0, txStart}, 16'h1);
    doWr(4'd10, 16'h0000);
    check("R11 bact cancel", {15'd0, txCancel}, 16'h1);
    check("R11 mask zero", activeMask, 16'h0);

    // master clear
    doWr(4'd0, 16'h0040);
    doWr(4'd8, 16'h0007);
    doWr(4'd10, 16'h0002);
    doWr(4'd12, 16'h0003);
    doWr(4'd0, 16'hA840);
    check("R9 txIrq", {15'd0, txIrq}, 16'h0);
    check("R9 activeMask", activeMask, 16'h0);
    check("R9 breakMask", breakMask, 16'h0);
    doRd(4'd0, v); check("R9 ctrl", v, 16'h0);
    doRd(4'd8, v); check("R9 bank", v, 16'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule